// File: doc/BRIEF.md
# Exception Control and Status Stack

This block sits beside a simple 32-bit in-order pipeline and decides, once per cycle, whether control must leave the normal instruction stream. The fetch, decode, execute and memory stages each report their own fault requests with the program counter and delay-slot flag of the instruction that raised them. Eight interrupt sources also feed the block: six hardware lines and two bits that software sets. The block picks a single winner by fixed priority. It records a 5-bit cause code and a return address, and it pushes a three-level stack of user-mode and interrupt-enable bits. It also drives a redirect address toward the handler. Every exception uses the same handler address. Which of the two handler addresses is used depends on a bootstrap bit that is set at reset.

A return command pops the stack. Software reaches the status, cause and return-address registers through a small read/write port. Exception entry is shown on `exc_taken` in the same cycle as the request. All of the state updates at the following clock edge.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, status reads 0x00400000, the cause register reads zero apart from the live hardware pending bits, the return-address register reads zero, and `redirect_pc` is 0xBFC00180.
- R2: `redirect_pc` is 0xBFC00180 when status bit 22 (bootstrap) is 1 and 0x80000080 when it is 0. A status write updates it from the next cycle on.
- R3: When several requests are active in one cycle, the winner is chosen in this order. Memory stage first: bit0 load address error (code 4), then bit1 store address error (code 5), then bit2 data bus error (code 7). Next the execute overflow (code 12). Then the decode stage: bit0 reserved instruction (code 10), bit1 coprocessor unusable (code 11), bit2 syscall (code 8), bit3 breakpoint (code 9). Then the fetch stage: bit0 fetch address error (code 4), then bit1 fetch bus error (code 6). Interrupts (code 0) come last. The winning code is stored in cause bits 6:2.
- R4: On an exception, status bits 5:0 (bit0 current IE, bit1 current user mode, bits 3:2 previous pair, bits 5:4 old pair) shift left by two and become {old=previous, previous=current, current=kernel with IE 0}, and `exc_taken` is 1.
- R5: On an exception, the return-address register takes the winning stage's PC. If that stage's delay-slot flag is set, it takes that PC minus 4 instead, and cause bit 31 is set. Otherwise bit 31 is cleared.
- R6: An interrupt is taken only when no other request is active and current IE is 1 and at least one source is both pending and enabled in status bits 15:8. Bits 9:8 are the software sources and bits 15:10 are hardware lines 0 to 5.
- R7: Cause bits 15:10 always show the live hardware lines and cannot be written. Cause bits 9:8 are written by software and act as pending interrupt sources.
- R8: A return command without an exception copies the previous pair into current and the old pair into previous, and leaves the old pair as it was.
- R9: An exception in the same cycle as a return command or a register write ignores both. A status write in the same cycle as a return command takes effect over the pop.
- R10: The cause code field never holds 1, 2, 3 or a value above 12.
- R11: Writes to the return-address register and to the cause bits other than 9:8 have no effect. Register address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | 6 | Hardware interrupt lines |
| if_req | input | 2 | Fetch-stage requests: bit0 address error, bit1 bus error |
| if_pc | input | 32 | PC of the fetch-stage instruction |
| if_bd | input | 1 | Fetch-stage instruction is in a delay slot |
| id_req | input | 4 | Decode requests: bit0 reserved, bit1 coprocessor, bit2 syscall, bit3 breakpoint |
| id_pc | input | 32 | PC of the decode-stage instruction |
| id_bd | input | 1 | Decode-stage instruction is in a delay slot |
| ex_ovf | input | 1 | Execute-stage arithmetic overflow |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| ex_bd | input | 1 | Execute-stage instruction is in a delay slot |
| mem_req | input | 3 | Memory requests: bit0 load address error, bit1 store address error, bit2 bus error |
| mem_pc | input | 32 | PC of the memory-stage instruction |
| mem_bd | input | 1 | Memory-stage instruction is in a delay slot |
| int_pc | input | 32 | Restart PC used when an interrupt is taken |
| int_bd | input | 1 | Interrupt restart point is in a delay slot |
| rfe | input | 1 | Return-from-exception command |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 status, 1 cause, 2 return address, 3 none |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| exc_taken | output | 1 | An exception is taken this cycle |
| redirect_pc | output | 32 | Handler address |

## Verification
The bench builds the block with its default handler addresses, 0xBFC00180 and 0x80000080. With these, random writes to the bootstrap bit move the redirect between two known values, and both can be checked directly. Random requests are sparse, so many cycles carry none. This lets interrupt gating be tested against random masks, random enable states and random software pending bits, and it lets return commands pop stacks that earlier exceptions built up. Collisions of requests with writes and with returns occur often enough to check the precedence rules.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter logic [31:0] BOOT_VEC = 32'hBFC0_0180,
  parameter logic [31:0] NORM_VEC = 32'h8000_0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  hw_irq,
  input  logic [1:0]  if_req,
  input  logic [31:0] if_pc,
  input  logic        if_bd,
  input  logic [3:0]  id_req,
  input  logic [31:0] id_pc,
  input  logic        id_bd,
  input  logic        ex_ovf,
  input  logic [31:0] ex_pc,
  input  logic        ex_bd,
  input  logic [2:0]  mem_req,
  input  logic [31:0] mem_pc,
  input  logic        mem_bd,
  input  logic [31:0] int_pc,
  input  logic        int_bd,
  input  logic        rfe,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        exc_taken,
  output logic [31:0] redirect_pc
);
  localparam logic [4:0] C_INT = 5'd0,  C_ADL = 5'd4,  C_ADS = 5'd5,  C_IBE = 5'd6;
  localparam logic [4:0] C_DBE = 5'd7,  C_SYS = 5'd8,  C_BRK = 5'd9,  C_RSV = 5'd10;
  localparam logic [4:0] C_CPU = 5'd11, C_OVF = 5'd12;

  logic        bev;
  logic [7:0]  im;
  logic [5:0]  sr;
  logic [1:0]  sw_ip;
  logic [4:0]  code;
  logic        bd;
  logic [31:0] epc;

  logic [4:0]  sel_code;
  logic [31:0] sel_pc;
  logic        sel_bd;
  logic        sync_go, irq_go;
  logic [7:0]  irq_hit;
  logic        wr_ok, wr_sr, wr_cause;

  assign irq_hit  = {hw_irq, sw_ip} & im;
  assign irq_go   = sr[0] & (|irq_hit);
  assign sync_go  = |{mem_req, ex_ovf, id_req, if_req};
  assign exc_taken = sync_go | irq_go;
  assign redirect_pc = bev ? BOOT_VEC : NORM_VEC;

  assign wr_ok    = reg_wr_en & ~exc_taken;
  assign wr_sr    = wr_ok & (reg_addr == 2'd0);
  assign wr_cause = wr_ok & (reg_addr == 2'd1);

  always_comb begin
    sel_code = C_INT;
    sel_pc   = int_pc;
    sel_bd   = int_bd;
    if (|mem_req) begin
      sel_pc = mem_pc;
      sel_bd = mem_bd;
      if (mem_req[0])      sel_code = C_ADL;
      else if (mem_req[1]) sel_code = C_ADS;
      else                 sel_code = C_DBE;
    end else if (ex_ovf) begin
      sel_pc   = ex_pc;
      sel_bd   = ex_bd;
      sel_code = C_OVF;
    end else if (|id_req) begin
      sel_pc = id_pc;
      sel_bd = id_bd;
      if (id_req[0])      sel_code = C_RSV;
      else if (id_req[1]) sel_code = C_CPU;
      else if (id_req[2]) sel_code = C_SYS;
      else                sel_code = C_BRK;
    end else if (|if_req) begin
      sel_pc   = if_pc;
      sel_bd   = if_bd;
      sel_code = if_req[0] ? C_ADL : C_IBE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bev   <= 1'b1;
      im    <= '0;
      sr    <= '0;
      sw_ip <= '0;
      code  <= C_INT;
      bd    <= 1'b0;
      epc   <= '0;
    end else if (exc_taken) begin
      sr   <= {sr[3:0], 2'b00};
      code <= sel_code;
      bd   <= sel_bd;
      epc  <= sel_bd ? sel_pc - 32'd4 : sel_pc;
    end else begin
      if (rfe) sr <= {sr[5:4], sr[5:2]};
      if (wr_sr) begin
        bev <= reg_wdata[22];
        im  <= reg_wdata[15:8];
        sr  <= reg_wdata[5:0];
      end
      if (wr_cause) sw_ip <= reg_wdata[9:8];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {9'b0, bev, 6'b0, im, 2'b0, sr};
      2'd1:    reg_rdata = {bd, 15'b0, hw_irq, sw_ip, 1'b0, code, 2'b0};
      2'd2:    reg_rdata = epc;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter logic [31:0] BOOT_VEC = 32'hBFC0_0180,
  parameter logic [31:0] NORM_VEC = 32'h8000_0080
) (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_taken,
  input logic        rfe,
  input logic        sync_go,
  input logic        bev,
  input logic        wr_sr,
  input logic [7:0]  irq_hit,
  input logic [5:0]  sr,
  input logic [4:0]  code,
  input logic [31:0] redirect_pc
);
  p_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_pc == (bev ? BOOT_VEC : NORM_VEC));

  p_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> sr == {$past(sr[3:0]), 2'b00});

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && !sync_go) |-> (sr[0] && (|irq_hit)));

  p_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !exc_taken && !wr_sr) |=> sr == {$past(sr[5:4]), $past(sr[5:2])});

  p_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (code <= 5'd12) && !(code >= 5'd1 && code <= 5'd3));
endmodule

bind exc_ctrl exc_ctrl_chk #(.BOOT_VEC(BOOT_VEC), .NORM_VEC(NORM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_taken(exc_taken), .rfe(rfe), .sync_go(sync_go),
  .bev(bev), .wr_sr(wr_sr), .irq_hit(irq_hit), .sr(sr), .code(code),
  .redirect_pc(redirect_pc)
);

// File: tb/tb_exc_ctrl.sv
`timescale 1ns/100ps
module tb_exc_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [5:0] hw_irq;
  logic [1:0] if_req;  logic [31:0] if_pc;  logic if_bd;
  logic [3:0] id_req;  logic [31:0] id_pc;  logic id_bd;
  logic ex_ovf;        logic [31:0] ex_pc;  logic ex_bd;
  logic [2:0] mem_req; logic [31:0] mem_pc; logic mem_bd;
  logic [31:0] int_pc; logic int_bd;
  logic rfe, reg_wr_en;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, redirect_pc;
  logic exc_taken;

  exc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq),
    .if_req(if_req), .if_pc(if_pc), .if_bd(if_bd),
    .id_req(id_req), .id_pc(id_pc), .id_bd(id_bd),
    .ex_ovf(ex_ovf), .ex_pc(ex_pc), .ex_bd(ex_bd),
    .mem_req(mem_req), .mem_pc(mem_pc), .mem_bd(mem_bd),
    .int_pc(int_pc), .int_bd(int_bd), .rfe(rfe),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .exc_taken(exc_taken), .redirect_pc(redirect_pc)
  );

  int n_chk = 0, n_bad = 0;
  logic [5:0] m_sr; logic m_bev; logic [7:0] m_im; logic [1:0] m_sw;
  logic [4:0] m_code; logic m_bd; logic [31:0] m_epc;
  logic e_hit; logic [4:0] e_code; logic [31:0] e_pc; logic e_bd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_code();
    if (mem_req[0]) return 5'd4;
    if (mem_req[1]) return 5'd5;
    if (mem_req[2]) return 5'd7;
    if (ex_ovf)     return 5'd12;
    if (id_req[0])  return 5'd10;
    if (id_req[1])  return 5'd11;
    if (id_req[2])  return 5'd8;
    if (id_req[3])  return 5'd9;
    if (if_req[0])  return 5'd4;
    if (if_req[1])  return 5'd6;
    return 5'd0;
  endfunction

  task automatic predict();
    logic sync;
    sync = (mem_req != 0) || ex_ovf || (id_req != 0) || (if_req != 0);
    e_hit  = sync || (m_sr[0] && ((({hw_irq, m_sw}) & m_im) != 8'h0));
    e_code = exp_code();
    if (mem_req != 0)     begin e_pc = mem_pc; e_bd = mem_bd; end
    else if (ex_ovf)      begin e_pc = ex_pc;  e_bd = ex_bd;  end
    else if (id_req != 0) begin e_pc = id_pc;  e_bd = id_bd;  end
    else if (if_req != 0) begin e_pc = if_pc;  e_bd = if_bd;  end
    else                  begin e_pc = int_pc; e_bd = int_bd; end
  endtask

  task automatic read_all();
    logic [1:0] a;
    logic [31:0] w;
    a = reg_addr; w = reg_wdata;
    reg_wr_en = 1'b0;
    reg_addr = 2'd0; #0.5;
    chk("R4/R8/R9 status", reg_rdata, {9'b0, m_bev, 6'b0, m_im, 2'b0, m_sr});
    reg_addr = 2'd1; #0.5;
    chk("R3/R5/R7/R11 cause", reg_rdata, {m_bd, 15'b0, hw_irq, m_sw, 1'b0, m_code, 2'b0});
    chk("R10 code range", {31'b0, (m_code <= 5'd12) && !(m_code >= 5'd1 && m_code <= 5'd3)}, 32'd1);
    reg_addr = 2'd2; #0.5;
    chk("R5/R11 epc", reg_rdata, m_epc);
    reg_addr = 2'd3; #0.5;
    chk("R11 unused address", reg_rdata, 32'h0);
    reg_addr = a; reg_wdata = w;
  endtask

  task automatic step(input logic wr);
    reg_wr_en = wr;
    #0.5;
    predict();
    chk("R3/R6 exc_taken", {31'b0, exc_taken}, {31'b0, e_hit});
    chk("R2 redirect", redirect_pc, m_bev ? 32'hBFC0_0180 : 32'h8000_0080);
    @(posedge clk);
    if (e_hit) begin
      m_sr = {m_sr[3:0], 2'b00};
      m_code = e_code; m_bd = e_bd;
      m_epc = e_bd ? e_pc - 32'd4 : e_pc;
    end else begin
      if (rfe) m_sr = {m_sr[5:4], m_sr[5:2]};
      if (wr && reg_addr == 2'd0) begin
        m_bev = reg_wdata[22]; m_im = reg_wdata[15:8]; m_sr = reg_wdata[5:0];
      end
      if (wr && reg_addr == 2'd1) m_sw = reg_wdata[9:8];
    end
    @(negedge clk);
    read_all();
  endtask

  task automatic idle();
    if_req = 0; id_req = 0; ex_ovf = 0; mem_req = 0; rfe = 0;
    reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; hw_irq = 0; idle();
    if_pc = 32'h100; id_pc = 32'h200; ex_pc = 32'h300; mem_pc = 32'h400; int_pc = 32'h500;
    if_bd = 0; id_bd = 0; ex_bd = 0; mem_bd = 0; int_bd = 0;
    m_sr = 0; m_bev = 1; m_im = 0; m_sw = 0; m_code = 0; m_bd = 0; m_epc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    reg_addr = 2'd0; #0.5; chk("R1 reset status", reg_rdata, 32'h0040_0000);
    reg_addr = 2'd1; #0.5; chk("R1 reset cause", reg_rdata, 32'h0);
    reg_addr = 2'd2; #0.5; chk("R1 reset epc", reg_rdata, 32'h0);
    chk("R1 reset redirect", redirect_pc, 32'hBFC0_0180);

    // R2: clear bootstrap, enable all sources, IE on
    reg_addr = 0; reg_wdata = 32'h0000_FF01; step(1'b1);
    chk("R2 vector after write", redirect_pc, 32'h8000_0080);
    // R6/R4: hardware interrupt taken
    idle(); hw_irq = 6'b000100; step(1'b0);
    chk("R4 kernel entry", {26'b0, m_sr}, {26'b0, 6'b000100});
    // R8: return pops
    hw_irq = 0; rfe = 1; step(1'b0);
    // R5: delay slot on execute overflow, with a fetch request too (R3)
    idle(); ex_ovf = 1; ex_pc = 32'h0000_1008; ex_bd = 1; if_req = 2'b11; step(1'b0);
    chk("R5 delay slot epc", m_epc, 32'h0000_1004);
    // R9: exception with write and return same cycle
    idle(); mem_req = 3'b110; rfe = 1; reg_addr = 0; reg_wdata = 32'h0040_0000; step(1'b1);
    // R7: software pending raises interrupt once enabled
    idle(); reg_addr = 1; reg_wdata = 32'hFFFF_FFFF; step(1'b1);
    idle(); reg_addr = 0; reg_wdata = 32'h0000_0101; step(1'b1);
    idle(); step(1'b0);
    // R11: epc write ignored
    idle(); reg_addr = 2; reg_wdata = 32'hDEAD_BEEF; step(1'b1);

    for (int i = 0; i < 4000; i++) begin
      logic wr;
      idle();
      for (int b = 0; b < 3; b++) mem_req[b] = ($urandom % 28) == 0;
      ex_ovf = ($urandom % 28) == 0;
      for (int b = 0; b < 4; b++) id_req[b] = ($urandom % 28) == 0;
      for (int b = 0; b < 2; b++) if_req[b] = ($urandom % 28) == 0;
      hw_irq = (($urandom % 3) == 0) ? 6'($urandom) : 6'h0;
      if_pc = $urandom & ~32'h3; id_pc = $urandom & ~32'h3; ex_pc = $urandom & ~32'h3;
      mem_pc = $urandom & ~32'h3; int_pc = $urandom & ~32'h3;
      if_bd = ($urandom % 4) == 0; id_bd = ($urandom % 4) == 0; ex_bd = ($urandom % 4) == 0;
      mem_bd = ($urandom % 4) == 0; int_bd = ($urandom % 4) == 0;
      rfe = ($urandom % 6) == 0;
      wr = ($urandom % 5) == 0;
      reg_addr = 2'($urandom);
      reg_wdata = $urandom;
      step(wr);
    end
    finish_run();
  end
endmodule